// File: doc/BRIEF.md
# Dirty-Chunk Flash Write-Back Scanner

This block keeps a serial flash image in step with a RAM working copy that a host is free to write at any time. The RAM is split into equal chunks of `2**CHUNK_W` bytes, and every chunk owns one dirty flag. Any host write strobe marks the chunk that holds the written address. The flash only ever receives chunks that actually changed, so wear stays low. When nothing is marked, the flash sees no traffic at all.

A background scanner picks one marked chunk at a time. It looks in round-robin order, beginning just after the chunk it serviced last. It clears the chunk's flag at the moment it selects the chunk, which is before any byte is copied. It then opens a job to the flash page-program engine, streams the chunk's bytes out of the RAM read port, and waits for the engine to report completion. The flag is cleared before the copy, so a host write that lands during the copy marks the chunk again, and the chunk is copied once more later. No change is lost.

The SPI command sequencing and erase handling live in the flash engine and are not part of this block. This block only raises the job request.

Top module: `chunk_flash_writeback`

## Requirements
- R1: A cycle with `host_wr` high marks chunk `host_addr[ADDR_W-1:CHUNK_W]` dirty. `busy` is high in the cycle after the write.
- R2: A chunk's flag is cleared in the cycle the scanner selects it. A host write to that chunk at any later point of its job leaves it marked, and the chunk gets a further job after the current one.
- R3: A host write to a chunk in the same cycle that the scanner clears that chunk's flag leaves the flag set.
- R4: Only marked chunks get jobs. Several writes to one chunk before it is selected result in a single job.
- R5: While no flag is set and no job is open, `job_start` and `ram_rd_en` stay low.
- R6: The scanner selects the first marked chunk in ascending index order that comes after the last serviced chunk, wrapping from the highest index to 0.
- R7: A job begins with a one-cycle `job_start` pulse, with `job_addr` equal to the chunk index shifted left by `CHUNK_W`. In that cycle and the following ones, `ram_rd_en` reads offsets 0 up to `2**CHUNK_W-1` in ascending order. Read data returns one cycle after each read and is forwarded on `job_data` with `job_valid` high. `job_last` is high only with the final byte.
- R8: After a job starts, no further `job_start` occurs until `job_done` has been seen high. `job_done` outside an open job is ignored.
- R9: `busy` is high while any flag is set or a job is open. It returns low after the last `job_done` once no flag remains.
- R10: After reset, `busy`, `job_start`, `ram_rd_en`, `job_valid` and `job_last` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe into the RAM copy |
| host_addr | input | ADDR_W | Byte address of the host write |
| ram_rd_en | output | 1 | Scanner read request to the RAM |
| ram_rd_addr | output | ADDR_W | Scanner read byte address |
| ram_rd_data | input | DATA_W | Read data, valid one cycle after `ram_rd_en` |
| job_start | output | 1 | One-cycle pulse that opens a flash page-program job |
| job_addr | output | ADDR_W | Flash byte address of the chunk in the job |
| job_valid | output | 1 | Qualifies `job_data` |
| job_data | output | DATA_W | Chunk byte streamed to the flash engine |
| job_last | output | 1 | Marks the final byte of the chunk |
| job_done | input | 1 | Flash engine reports that the open job has finished |
| busy | output | 1 | Flags pending or a job open |

## Verification
The bench builds the block with `ADDR_W=6`, `CHUNK_W=2` and `DATA_W=8`. That gives sixteen chunks of four bytes, so the round-robin wrap from chunk 15 back to chunk 0 and the last-byte marker come up within a few writes. It holds every `job_done` back for several cycles, which opens the window in which host writes re-mark the chunk being copied. One write pattern lands in the exact cycle of selection, which exercises the set-over-clear case. With the short chunks, every job's bytes and address can be compared against an address-derived RAM pattern.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [1:0] {
    WB_IDLE   = 2'd0,
    WB_STREAM = 2'd1,
    WB_WAIT   = 2'd2
  } wb_state_e;
endpackage

// File: rtl/chunk_dirty_map.sv
module chunk_dirty_map #(
  parameter int NCHUNK = 64,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  output logic [NCHUNK-1:0] flags,
  output logic              any_set
);
  logic [NCHUNK-1:0] flags_q, flags_d;

  // one flag per chunk; a set in the same cycle as a clear wins
  generate
    for (genvar g = 0; g < NCHUNK; g++) begin : g_flag
      logic hit_set, hit_clr;
      assign hit_set = set_en && (set_idx == IDX_W'(g));
      assign hit_clr = clr_en && (clr_idx == IDX_W'(g));
      always_comb begin
        flags_d[g] = flags_q[g];
        if (hit_clr) flags_d[g] = 1'b0;
        if (hit_set) flags_d[g] = 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags   = flags_q;
  assign any_set = |flags_q;
endmodule

// File: rtl/rr_chunk_pick.sv
module rr_chunk_pick #(
  parameter int NCHUNK = 64,
  parameter int IDX_W  = 6
) (
  input  logic [NCHUNK-1:0] flags,
  input  logic [IDX_W-1:0]  last_idx,
  output logic              found,
  output logic [IDX_W-1:0]  pick
);
  // search starts one past the last serviced chunk and wraps
  always_comb begin
    logic [IDX_W-1:0] cand;
    found = 1'b0;
    pick  = '0;
    cand  = '0;
    for (int i = 0; i < NCHUNK; i++) begin
      cand = last_idx + IDX_W'(i + 1);
      if (!found && flags[cand]) begin
        found = 1'b1;
        pick  = cand;
      end
    end
  end
endmodule

// File: rtl/wb_sequencer.sv
module wb_sequencer
  import wb_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int OFF_W  = 4,
  parameter int DATA_W = 8,
  localparam int ADDR_W = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pick_found,
  input  logic [IDX_W-1:0]  pick_idx,
  output logic              clr_en,
  output logic [IDX_W-1:0]  clr_idx,
  output logic [IDX_W-1:0]  last_idx,
  output logic              ram_rd_en,
  output logic [ADDR_W-1:0] ram_rd_addr,
  input  logic [DATA_W-1:0] ram_rd_data,
  output logic              job_start,
  output logic [ADDR_W-1:0] job_addr,
  output logic              job_valid,
  output logic [DATA_W-1:0] job_data,
  output logic              job_last,
  input  logic              job_done,
  output logic              active
);
  localparam logic [OFF_W-1:0] OFF_MAX = {OFF_W{1'b1}};

  wb_state_e        state_q, state_d;
  logic [IDX_W-1:0] cur_q, cur_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic             vld_q, vld_d;
  logic             lst_q, lst_d;
  logic             cur_en, off_en, last_en;

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    off_d   = off_q;
    last_d  = last_q;
    cur_en  = 1'b0;
    off_en  = 1'b0;
    last_en = 1'b0;
    clr_en  = 1'b0;
    unique case (state_q)
      WB_IDLE: begin
        if (pick_found) begin
          clr_en  = 1'b1;
          cur_d   = pick_idx;
          cur_en  = 1'b1;
          off_d   = '0;
          off_en  = 1'b1;
          state_d = WB_STREAM;
        end
      end
      WB_STREAM: begin
        off_d  = off_q + 1'b1;
        off_en = 1'b1;
        if (off_q == OFF_MAX) state_d = WB_WAIT;
      end
      WB_WAIT: begin
        if (job_done) begin
          last_d  = cur_q;
          last_en = 1'b1;
          state_d = WB_IDLE;
        end
      end
      default: state_d = WB_IDLE;
    endcase
  end

  assign clr_idx     = pick_idx;
  assign ram_rd_en   = (state_q == WB_STREAM);
  assign ram_rd_addr = {cur_q, off_q};
  assign job_start   = (state_q == WB_STREAM) && (off_q == '0);
  assign job_addr    = {cur_q, {OFF_W{1'b0}}};
  assign vld_d       = ram_rd_en;
  assign lst_d       = ram_rd_en && (off_q == OFF_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WB_IDLE;
      cur_q   <= '0;
      off_q   <= '0;
      last_q  <= '1;
      vld_q   <= 1'b0;
      lst_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      vld_q   <= vld_d;
      lst_q   <= lst_d;
      if (cur_en)  cur_q  <= cur_d;
      if (off_en)  off_q  <= off_d;
      if (last_en) last_q <= last_d;
    end
  end

  assign last_idx  = last_q;
  assign job_valid = vld_q;
  assign job_last  = lst_q;
  assign job_data  = ram_rd_data;
  assign active    = (state_q != WB_IDLE) || vld_q;
endmodule

// File: rtl/chunk_flash_writeback.sv
module chunk_flash_writeback #(
  parameter int ADDR_W  = 10,
  parameter int CHUNK_W = 4,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              ram_rd_en,
  output logic [ADDR_W-1:0] ram_rd_addr,
  input  logic [DATA_W-1:0] ram_rd_data,
  output logic              job_start,
  output logic [ADDR_W-1:0] job_addr,
  output logic              job_valid,
  output logic [DATA_W-1:0] job_data,
  output logic              job_last,
  input  logic              job_done,
  output logic              busy
);
  localparam int IDX_W  = ADDR_W - CHUNK_W;
  localparam int NCHUNK = 1 << IDX_W;

  logic [NCHUNK-1:0] flags;
  logic              any_set;
  logic              clr_en;
  logic [IDX_W-1:0]  clr_idx;
  logic [IDX_W-1:0]  last_idx;
  logic              pick_found;
  logic [IDX_W-1:0]  pick_idx;
  logic              active;

  chunk_dirty_map #(.NCHUNK(NCHUNK), .IDX_W(IDX_W)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (host_wr),
    .set_idx (host_addr[ADDR_W-1:CHUNK_W]),
    .clr_en  (clr_en),
    .clr_idx (clr_idx),
    .flags   (flags),
    .any_set (any_set)
  );

  rr_chunk_pick #(.NCHUNK(NCHUNK), .IDX_W(IDX_W)) u_pick (
    .flags    (flags),
    .last_idx (last_idx),
    .found    (pick_found),
    .pick     (pick_idx)
  );

  wb_sequencer #(.IDX_W(IDX_W), .OFF_W(CHUNK_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .pick_found  (pick_found),
    .pick_idx    (pick_idx),
    .clr_en      (clr_en),
    .clr_idx     (clr_idx),
    .last_idx    (last_idx),
    .ram_rd_en   (ram_rd_en),
    .ram_rd_addr (ram_rd_addr),
    .ram_rd_data (ram_rd_data),
    .job_start   (job_start),
    .job_addr    (job_addr),
    .job_valid   (job_valid),
    .job_data    (job_data),
    .job_last    (job_last),
    .job_done    (job_done),
    .active      (active)
  );

  assign busy = any_set || active;
endmodule

// File: rtl/chunk_flash_writeback_checker.sv
module chunk_flash_writeback_checker (
  input logic clk,
  input logic rst_n,
  input logic host_wr,
  input logic ram_rd_en,
  input logic job_start,
  input logic job_valid,
  input logic job_last,
  input logic job_done,
  input logic busy
);
  logic open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         open_q <= 1'b0;
    else if (job_start) open_q <= 1'b1;
    else if (job_done)  open_q <= 1'b0;
  end

  assert_write_marks_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> busy);

  assert_quiet_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!job_start && !ram_rd_en));

  assert_start_is_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    job_start |=> !job_start);

  assert_read_returns_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_en |=> job_valid);

  assert_last_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
    job_last |-> job_valid);

  assert_wait_for_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    job_start |-> !open_q);

  assert_busy_during_job_R9: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> busy);
endmodule

bind chunk_flash_writeback chunk_flash_writeback_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_wr   (host_wr),
  .ram_rd_en (ram_rd_en),
  .job_start (job_start),
  .job_valid (job_valid),
  .job_last  (job_last),
  .job_done  (job_done),
  .busy      (busy)
);

// File: tb/chunk_flash_writeback_test.sv
module chunk_flash_writeback_test;
  localparam int AW = 6;
  localparam int CW = 2;
  localparam int DW = 8;
  localparam int NB = 1 << CW;
  localparam int NONE = 31;
  localparam int NVEC = 6;
  // fields: write c0, c1, c2 | expected job order e0, e1, e2 (31 = no job)
  localparam logic [29:0] VEC [NVEC] = '{
    {5'd3,  5'd9,  5'd1,  5'd3,  5'd9,  5'd1},
    {5'd12, 5'd5,  5'd14, 5'd12, 5'd14, 5'd5},
    {5'd0,  5'd15, 5'd7,  5'd0,  5'd7,  5'd15},
    {5'd6,  5'd6,  5'd2,  5'd6,  5'd2,  5'd6},
    {5'd10, 5'd11, 5'd10, 5'd10, 5'd11, 5'd10},
    {5'd8,  5'd4,  5'd4,  5'd8,  5'd4,  5'd31}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_wr;
  logic [AW-1:0] host_addr;
  logic          ram_rd_en;
  logic [AW-1:0] ram_rd_addr;
  logic [DW-1:0] ram_rd_data;
  logic          job_start;
  logic [AW-1:0] job_addr;
  logic          job_valid;
  logic [DW-1:0] job_data;
  logic          job_last;
  logic          job_done;
  logic          busy;

  always #5 clk = ~clk;

  chunk_flash_writeback #(.ADDR_W(AW), .CHUNK_W(CW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_rd_data),
    .job_start(job_start), .job_addr(job_addr), .job_valid(job_valid),
    .job_data(job_data), .job_last(job_last), .job_done(job_done), .busy(busy)
  );

  int n_chk = 0;
  int n_fail = 0;
  int log_q [16];
  int log_n = 0;
  bit in_job = 0;
  int cur_base = 0;
  int byte_cnt = 0;
  int done_wait = 0;
  int cycles = 0;

  function automatic logic [DW-1:0] pat(logic [AW-1:0] a);
    return DW'(a) * 8'd37 + 8'd11;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // RAM copy: one cycle read latency
  always @(posedge clk) if (ram_rd_en) ram_rd_data <= pat(ram_rd_addr);

  // flash engine model
  always @(negedge clk) begin
    if (rst_n) begin
      if (job_done) begin
        job_done <= 1'b0;
        in_job = 0;
      end
      if (job_start) begin
        chk(!in_job, "R8 start while job open", 1, 0);
        chk(job_addr[CW-1:0] == '0, "R7 job address alignment", int'(job_addr), int'(job_addr) & ~(NB - 1));
        in_job = 1;
        cur_base = int'(job_addr);
        byte_cnt = 0;
        if (log_n < 16) log_q[log_n] = int'(job_addr) >> CW;
        log_n++;
      end
      if (ram_rd_en) chk(in_job, "R5 RAM read outside job", 0, 1);
      if (job_valid) begin
        chk(job_data == pat(AW'(cur_base + byte_cnt)), "R7 byte data/order", int'(job_data), int'(pat(AW'(cur_base + byte_cnt))));
        chk(job_last == (byte_cnt == NB - 1), "R7 last marker", int'(job_last), int'(byte_cnt == NB - 1));
        byte_cnt++;
        if (job_last) done_wait = 6;
      end
      if (done_wait > 0) begin
        done_wait--;
        if (done_wait == 0) job_done <= 1'b1;
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wait_idle();
    int t;
    t = 0;
    @(negedge clk);
    while ((busy || in_job) && t < 2000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    host_wr = 1'b0;
    host_addr = '0;
    job_done = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!busy && !job_start && !ram_rd_en && !job_valid && !job_last, "R10 reset outputs",
        int'({busy, job_start, ram_rd_en, job_valid, job_last}), 0);
    rst_n = 1'b1;

    // R5: nothing marked, nothing happens
    repeat (40) @(negedge clk);
    chk(log_n == 0, "R5 no job without flags", log_n, 0);
    chk(!busy, "R9 idle busy low", int'(busy), 0);

    // stimulus/expectation table
    for (int v = 0; v < NVEC; v++) begin
      int c [3];
      int e [3];
      int exp_n;
      for (int k = 0; k < 3; k++) begin
        c[k] = int'(VEC[v][29 - 5*k -: 5]);
        e[k] = int'(VEC[v][14 - 5*k -: 5]);
      end
      exp_n = (e[2] == NONE) ? 2 : 3;
      log_n = 0;
      for (int k = 0; k < 3; k++) begin
        host_wr = 1'b1;
        host_addr = AW'((c[k] << CW) + ((v + k) % NB));
        @(negedge clk);
        if (k == 0) chk(busy, "R1 busy after write", int'(busy), 1);
      end
      host_wr = 1'b0;
      wait_idle();
      chk(log_n == exp_n, "R4 job count", log_n, exp_n);
      for (int k = 0; k < 3; k++)
        if (k < exp_n) chk(log_q[k] == e[k], "R6 R2 R3 service order", log_q[k], e[k]);
      chk(!busy, "R9 busy falls after last job", int'(busy), 0);
    end

    // R8: stray job_done while idle is ignored
    job_done = 1'b1;
    @(negedge clk);
    job_done = 1'b0;
    repeat (5) @(negedge clk);
    chk(!busy && !job_start, "R8 stray done ignored", int'(busy), 0);

    // R2: write during wait-for-done re-arms the chunk
    log_n = 0;
    host_wr = 1'b1;
    host_addr = AW'(13 << CW);
    @(negedge clk);
    host_wr = 1'b0;
    repeat (NB + 3) @(negedge clk);
    chk(in_job, "R2 job open before rewrite", int'(in_job), 1);
    host_wr = 1'b1;
    host_addr = AW'((13 << CW) + 1);
    @(negedge clk);
    host_wr = 1'b0;
    wait_idle();
    chk(log_n == 2, "R2 rewrite count", log_n, 2);
    chk(log_q[1] == 13, "R2 rewrite chunk", log_q[1], 13);

    // R6: wrap from the highest chunk back to low indices
    log_n = 0;
    host_wr = 1'b1;
    host_addr = AW'(15 << CW);
    @(negedge clk);
    host_addr = AW'(1 << CW);
    @(negedge clk);
    host_addr = AW'(14 << CW);
    @(negedge clk);
    host_wr = 1'b0;
    wait_idle();
    chk(log_n == 3, "R6 wrap count", log_n, 3);
    chk(log_q[1] == 1, "R6 wrap second", log_q[1], 1);
    chk(log_q[2] == 14, "R6 wrap third", log_q[2], 14);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule